// File: doc/BRIEF.md
# Preamble Run Detector

This block watches a stream of single-cycle data pulses, already synchronized to the oscillator clock. It recognizes when the pulses form a steady preamble. The gap between pulses is measured in whole oscillator cycles. A run counter tracks how many pulses in a row are spaced at the expected period. A 2-bit select picks that period: one, two, three or four oscillator cycles.

Detection is armed only while a read is in progress and the zero-phase-start sequence has reported completion. The short patterns need 32 pulses in a row. The four-cycle pattern needs 16. When the run reaches that length, the detect output goes high and stays high until the read gate drops. The output can be wired straight to a frequency-lock release control.

Top module: `preamble_detect`

## Requirements
- R1: After reset, `detect` is low.
- R2: Pulses that arrive while `rd_gate` or `zps_done` is low are not counted. The first pulse after arming starts a fresh run.
- R3: `pat_sel` selects the expected pulse period: 2'b00 = 1 cycle, 2'b01 = 2 cycles, 2'b10 = 3 cycles, 2'b11 = 4 cycles. A steady run at any other period never raises `detect`.
- R4: For `pat_sel` 2'b00, 2'b01 and 2'b10, `detect` rises after the 32nd pulse in a row at the selected period, and not after the 31st.
- R5: For `pat_sel` 2'b11, `detect` rises after the 16th pulse in a row, and not after the 15th.
- R6: A pulse whose gap from the previous pulse differs from the selected period ends the run. That pulse counts as the first pulse of a new run.
- R7: A gap longer than four cycles (a missing pulse) always ends the run, even when it is a multiple of the period.
- R8: Once `detect` is high, it stays high while `rd_gate` is high. Mismatched pulses and `zps_done` do not change it.
- R9: `detect` is low in the cycle after any cycle with `rd_gate` low. This holds even when the completing pulse arrives in that same cycle.
- R10: `detect` is registered. It rises at the clock edge that samples the completing pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; each cycle is one T |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_gate | input | 1 | High during a read |
| zps_done | input | 1 | High once the zero-phase-start sequence has finished |
| data_pulse | input | 1 | One-cycle pulse per recorded code bit |
| pat_sel | input | 2 | Preamble period select |
| detect | output | 1 | Latched preamble-found flag |

## Verification
Two events can fall in the same cycle: the pulse that completes a run, and the fall of the read gate. The bench brings a run to one pulse short of the threshold. It then drives the final pulse in the same cycle that it drops `rd_gate`, and expects `detect` to stay low. The second such overlap is a mismatched pulse that also starts the next run. It is judged by counting exactly how many further pulses are needed before `detect` rises.

// File: rtl/preamble_detect.sv
module preamble_detect #(
  parameter int SHORT_RUN = 32,
  parameter int LONG_RUN  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_gate,
  input  logic       zps_done,
  input  logic       data_pulse,
  input  logic [1:0] pat_sel,
  output logic       detect
);
  localparam int MAX_PERIOD = 4;
  localparam int GAP_SAT    = MAX_PERIOD + 1;
  localparam int GAP_W      = $clog2(GAP_SAT + 1);
  localparam int RUN_MAX    = (SHORT_RUN > LONG_RUN) ? SHORT_RUN : LONG_RUN;
  localparam int RUN_W      = $clog2(RUN_MAX + 1);

  logic [GAP_W-1:0] gap_q;
  logic [RUN_W-1:0] run_q, run_nxt, need;
  logic [GAP_W-1:0] period;
  logic armed, match, hit;

  assign armed   = rd_gate & zps_done;
  assign period  = GAP_W'(pat_sel) + GAP_W'(1);
  assign match   = (gap_q == period);
  assign need    = (pat_sel == 2'b11) ? RUN_W'(LONG_RUN) : RUN_W'(SHORT_RUN);
  assign run_nxt = match ? run_q + RUN_W'(1) : RUN_W'(1);
  assign hit     = armed & data_pulse & (run_nxt >= need);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      gap_q <= GAP_W'(GAP_SAT);
    else if (!armed)
      gap_q <= GAP_W'(GAP_SAT);
    else if (data_pulse)
      gap_q <= GAP_W'(1);
    else if (gap_q != GAP_W'(GAP_SAT))
      gap_q <= gap_q + GAP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_q <= '0;
    else if (!armed)
      run_q <= '0;
    else if (data_pulse && !detect)
      run_q <= run_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      detect <= 1'b0;
    else if (!rd_gate)
      detect <= 1'b0;
    else if (hit)
      detect <= 1'b1;
  end
endmodule

// File: rtl/preamble_detect_chk.sv
module preamble_detect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_gate,
  input logic       zps_done,
  input logic       data_pulse,
  input logic [1:0] pat_sel,
  input logic       detect
);
  // R9
  gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_gate |=> !detect);

  // R8
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (detect && rd_gate) |=> detect);

  // R2
  unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!detect && !(rd_gate && zps_done)) |=> !detect);

  // R10
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(detect) |-> $past(data_pulse && rd_gate && zps_done));
endmodule

bind preamble_detect preamble_detect_chk u_chk (.*);

// File: tb/sim_preamble_detect.sv
`timescale 1ns/1ps
module sim_preamble_detect;
  logic clk = 0, rst_n = 0, rd_gate = 0, zps_done = 0, data_pulse = 0;
  logic [1:0] pat_sel = 0;
  logic detect;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  preamble_detect u0 (.clk(clk), .rst_n(rst_n), .rd_gate(rd_gate), .zps_done(zps_done),
                      .data_pulse(data_pulse), .pat_sel(pat_sel), .detect(detect));

  task automatic chk(string req, logic exp);
    total++;
    if (detect !== exp) begin
      bad++;
      $display("FAIL %s: detect=%b expected=%b at %0t", req, detect, exp, $time);
    end
  endtask

  task automatic tick(logic p);
    data_pulse = p;
    @(negedge clk);
    data_pulse = 0;
  endtask

  task automatic send(int per, int n);
    for (int i = 0; i < n; i++) begin
      tick(1);
      for (int j = 1; j < per; j++) tick(0);
    end
  endtask

  task automatic arm(logic [1:0] s);
    pat_sel = s; rd_gate = 1; zps_done = 1;
    tick(0); tick(0);
  endtask

  task automatic disarm();
    rd_gate = 0; zps_done = 0;
    tick(0); tick(0);
  endtask

  task automatic t_reset();
    chk("R1", 1'b0);
  endtask

  task automatic t_unarmed();
    pat_sel = 0; rd_gate = 0; zps_done = 1;
    send(1, 40); chk("R2 gate low", 1'b0);
    rd_gate = 1; zps_done = 0;
    send(1, 40); chk("R2 zps low", 1'b0);
    zps_done = 1; tick(0);
    send(1, 31); chk("R2 fresh run 31", 1'b0);
    send(1, 1);  chk("R2 fresh run 32", 1'b1);
    disarm();
  endtask

  task automatic t_short(logic [1:0] s);
    arm(s);
    send(int'(s) + 1, 31); chk("R4 31 pulses", 1'b0);
    send(int'(s) + 1, 1);  chk("R4 R10 32 pulses", 1'b1);
    disarm();
  endtask

  task automatic t_long();
    arm(2'b11);
    send(4, 15); chk("R5 15 pulses", 1'b0);
    send(4, 1);  chk("R5 16 pulses", 1'b1);
    disarm();
  endtask

  task automatic t_wrong_period();
    arm(2'b01);
    send(3, 40); chk("R3 3T on 2T select", 1'b0);
    disarm();
    arm(2'b10);
    send(2, 40); chk("R3 2T on 3T select", 1'b0);
    disarm();
  endtask

  task automatic t_restart();
    arm(2'b01);
    send(2, 20);
    tick(0);
    send(2, 30); chk("R6 new run 30", 1'b0);
    send(2, 1);  chk("R6 new run 31", 1'b0);
    send(2, 1);  chk("R6 new run 32", 1'b1);
    disarm();
  endtask

  task automatic t_missing();
    arm(2'b11);
    send(4, 10);
    for (int k = 0; k < 4; k++) tick(0);
    send(4, 15); chk("R7 after gap 15", 1'b0);
    send(4, 1);  chk("R7 after gap 16", 1'b1);
    disarm();
  endtask

  task automatic t_latch();
    arm(2'b00);
    send(1, 32); chk("R8 set", 1'b1);
    send(3, 5);  chk("R8 mismatches", 1'b1);
    zps_done = 0; tick(0); tick(0); chk("R8 zps low", 1'b1);
    rd_gate = 0; tick(0); chk("R9 cleared", 1'b0);
    zps_done = 0; tick(0);
  endtask

  task automatic t_collide();
    arm(2'b00);
    send(1, 31); chk("R9 pre", 1'b0);
    rd_gate = 0; tick(1); chk("R9 same cycle", 1'b0);
    tick(0);
    arm(2'b00);
    send(1, 31); chk("R9 rearm 31", 1'b0);
    send(1, 1);  chk("R9 rearm 32", 1'b1);
    disarm();
  endtask

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog: detect=%b expected=finish", detect);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_unarmed();
    t_short(2'b00);
    t_short(2'b01);
    t_short(2'b10);
    t_long();
    t_wrong_period();
    t_restart();
    t_missing();
    t_latch();
    t_collide();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule